// File: doc/BRIEF.md
# Line Write Buffer with Read Bypass

This block sits between a write-back cache and the next memory level. It holds up to four evicted or written-through cache lines, each a line address plus a 256-bit payload, and drains them to memory oldest first over a single memory port. That port also carries cache read misses. A pending read miss does not wait for the buffer to empty. It is first compared against every occupied slot. If no slot holds its line, the read goes to memory ahead of the remaining writes. If one or more slots hold it, the newest copy is returned straight from the buffer and memory is not touched.

On a read miss that evicts a dirty line, the cache presents the victim on the enqueue port in the same cycle as the read request. The victim is parked in the buffer. The fill read goes out first and the write-back follows later. Requests to memory are held steady until `mem_ready`. Read data comes back later on `mem_rvalid`. Only one memory transaction is outstanding at a time.

Top module: `line_wbuf`

## Requirements
- R1: After reset the buffer is empty, `enq_stall` is 0, `rd_req_ready` is 1, and `mem_valid` and `rd_resp_valid` are 0.
- R2: An enqueue is taken when `enq_valid` is 1 and `enq_stall` is 0. `enq_stall` is 1 exactly while all 4 slots are occupied. An enqueue offered while stalled has no effect and is never written to memory.
- R3: Buffered lines leave in arrival order. Each one appears once on the memory port with `mem_write`=1, its own address and its 256-bit data. It leaves the buffer in the cycle `mem_ready` accepts it.
- R4: A pending read whose line address matches no occupied slot is issued to memory (`mem_write`=0, `mem_addr` = read address) before any write still waiting in the buffer.
- R5: A pending read whose address matches one or more occupied slots is answered with the data of the most recently enqueued match and `rd_resp_fwd`=1. It causes no memory read, and the answer is given only while the memory port is idle.
- R6: For a read sent to memory, `rd_resp_valid` pulses for one cycle, the cycle after `mem_rvalid`, carrying `mem_rdata` with `rd_resp_fwd`=0.
- R7: Once `mem_valid` is raised, `mem_valid`, `mem_write` and `mem_addr` stay unchanged until `mem_ready` is seen. A read keeps the port until its data returns.
- R8: No write is started on the memory port while a read is pending. A write already on the port finishes before the read is issued.
- R9: A victim enqueued in the same cycle as a missing read request is held in the buffer. The read reaches memory before the victim's write-back.
- R10: `rd_req_ready` drops in the cycle after a read request is accepted and returns to 1 together with that read's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Line offered for buffering |
| enq_addr | input | 26 | Line address of offered line |
| enq_data | input | 256 | Line payload |
| enq_stall | output | 1 | Buffer full, offer refused |
| rd_req_valid | input | 1 | Read miss request |
| rd_req_addr | input | 26 | Line address of read miss |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_resp_valid | output | 1 | Read data pulse |
| rd_resp_fwd | output | 1 | Read data came from the buffer |
| rd_resp_data | output | 256 | Read line data |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 26 | Memory line address |
| mem_wdata | output | 256 | Write-back payload |
| mem_ready | input | 1 | Memory takes the request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 256 | Returned line data |

## Verification
A corrupted head or tail pointer shows up at the memory port at the next drain, at most two cycles after the port goes idle, as a wrong address or payload on a write. A slip in the age order of the comparator shows one cycle after the read reaches the head of the controller. It appears either as stale forwarded data or as an unnecessary memory read that should have been a forward. A wrong occupancy count shows in `enq_stall` in the cycle after the fourth line lands, or later as a dropped or duplicated write-back. A reference model checks every one of these outputs on every clock.

// File: rtl/line_wbuf_pkg.sv
package line_wbuf_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_RD_REQ  = 2'd1,
    PS_RD_WAIT = 2'd2,
    PS_WR_REQ  = 2'd3
  } port_state_e;
endpackage

// File: rtl/line_wbuf_store.sv
module line_wbuf_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enq_valid,
  input  logic [ADDR_W-1:0]             enq_addr,
  input  logic [LINE_W-1:0]             enq_data,
  input  logic                          pop,
  input  logic [PTR_W-1:0]              sel_idx,
  output logic                          full,
  output logic [DEPTH-1:0]              valid_vec,
  output logic [PTR_W-1:0]              head,
  output logic [DEPTH-1:0][ADDR_W-1:0]  addr_vec,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [LINE_W-1:0]             head_data,
  output logic [LINE_W-1:0]             sel_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] line_ram [DEPTH];
  logic [PTR_W-1:0]  tail;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              push;

  assign push   = enq_valid && !full;
  assign cnt_nx = cnt + CNT_W'(push) - CNT_W'(pop);

  // payload and tag storage: no reset, written at the tail slot
  always_ff @(posedge clk) begin
    if (push) begin
      line_ram[tail] <= enq_data;
      addr_vec[tail] <= enq_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      full      <= 1'b0;
      valid_vec <= '0;
    end else begin
      if (pop) begin
        head            <= head + 1'b1;
        valid_vec[head] <= 1'b0;
      end
      if (push) begin
        tail            <= tail + 1'b1;
        valid_vec[tail] <= 1'b1;
      end
      cnt  <= cnt_nx;
      full <= (cnt_nx == CNT_W'(DEPTH));
    end
  end

  assign head_addr = addr_vec[head];
  assign head_data = line_ram[head];
  assign sel_data  = line_ram[sel_idx];
endmodule

// File: rtl/line_wbuf_match.sv
module line_wbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0]             look_addr,
  input  logic [DEPTH-1:0]              valid_vec,
  input  logic [PTR_W-1:0]              head,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_vec,
  output logic                          hit,
  output logic [PTR_W-1:0]              hit_idx
);
  logic [DEPTH-1:0] eq;
  logic [PTR_W-1:0] slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = valid_vec[g] && (addr_vec[g] == look_addr);
  end

  // walk from oldest to newest; the last match seen is the youngest copy
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    slot    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = head + PTR_W'(i);
      if (eq[slot]) begin
        hit     = 1'b1;
        hit_idx = slot;
      end
    end
  end
endmodule

// File: rtl/line_wbuf_ctrl.sv
module line_wbuf_ctrl
  import line_wbuf_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_ready,
  output logic [ADDR_W-1:0] look_addr,
  input  logic              hit,
  input  logic [LINE_W-1:0] hit_data,
  input  logic              has_entry,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [LINE_W-1:0] head_data,
  output logic              pop,
  output logic              rd_resp_valid,
  output logic              rd_resp_fwd,
  output logic [LINE_W-1:0] rd_resp_data,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata
);
  port_state_e state;
  logic        rd_busy;

  assign rd_req_ready = !rd_busy;
  assign pop          = (state == PS_WR_REQ) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= PS_IDLE;
      rd_busy       <= 1'b0;
      look_addr     <= '0;
      mem_valid     <= 1'b0;
      mem_write     <= 1'b0;
      mem_addr      <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_fwd   <= 1'b0;
    end else begin
      rd_resp_valid <= 1'b0;
      if (rd_req_valid && !rd_busy) begin
        rd_busy   <= 1'b1;
        look_addr <= rd_req_addr;
      end
      unique case (state)
        PS_IDLE: begin
          if (rd_busy) begin
            if (hit) begin
              rd_resp_valid <= 1'b1;
              rd_resp_fwd   <= 1'b1;
              rd_resp_data  <= hit_data;
              rd_busy       <= 1'b0;
            end else begin
              mem_valid <= 1'b1;
              mem_write <= 1'b0;
              mem_addr  <= look_addr;
              state     <= PS_RD_REQ;
            end
          end else if (has_entry) begin
            mem_valid <= 1'b1;
            mem_write <= 1'b1;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
            state     <= PS_WR_REQ;
          end
        end
        PS_RD_REQ: if (mem_ready) begin
          mem_valid <= 1'b0;
          state     <= PS_RD_WAIT;
        end
        PS_RD_WAIT: if (mem_rvalid) begin
          rd_resp_valid <= 1'b1;
          rd_resp_fwd   <= 1'b0;
          rd_resp_data  <= mem_rdata;
          rd_busy       <= 1'b0;
          state         <= PS_IDLE;
        end
        PS_WR_REQ: if (mem_ready) begin
          mem_valid <= 1'b0;
          state     <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_wbuf.sv
module line_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [LINE_W-1:0] enq_data,
  output logic              enq_stall,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_ready,
  output logic              rd_resp_valid,
  output logic              rd_resp_fwd,
  output logic [LINE_W-1:0] rd_resp_data,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]             valid_vec;
  logic [PTR_W-1:0]             head, hit_idx;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_vec;
  logic [ADDR_W-1:0]            head_addr, look_addr;
  logic [LINE_W-1:0]            head_data, hit_data;
  logic                         pop, hit;

  line_wbuf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data),
    .pop(pop), .sel_idx(hit_idx),
    .full(enq_stall), .valid_vec(valid_vec), .head(head), .addr_vec(addr_vec),
    .head_addr(head_addr), .head_data(head_data), .sel_data(hit_data)
  );

  line_wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .look_addr(look_addr), .valid_vec(valid_vec), .head(head),
    .addr_vec(addr_vec), .hit(hit), .hit_idx(hit_idx)
  );

  line_wbuf_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .look_addr(look_addr), .hit(hit), .hit_data(hit_data),
    .has_entry(|valid_vec), .head_addr(head_addr), .head_data(head_data),
    .pop(pop),
    .rd_resp_valid(rd_resp_valid), .rd_resp_fwd(rd_resp_fwd), .rd_resp_data(rd_resp_data),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/line_wbuf_chk.sv
module line_wbuf_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              enq_stall,
  input logic [DEPTH-1:0]  valid_vec,
  input logic              rd_req_ready,
  input logic              rd_resp_valid,
  input logic              rd_resp_fwd,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready
);
  assert_stall_full_R2: assert property (@(posedge clk) disable iff (rst)
    enq_stall == (&valid_vec));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write) && $stable(mem_addr)));

  assert_no_write_over_read_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_valid) && mem_write) |-> $past(rd_req_ready));

  assert_fwd_port_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_resp_valid && rd_resp_fwd) |-> !$past(mem_valid));

  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_resp_valid |=> !rd_resp_valid);
endmodule

bind line_wbuf line_wbuf_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .enq_stall(enq_stall), .valid_vec(valid_vec),
  .rd_req_ready(rd_req_ready), .rd_resp_valid(rd_resp_valid), .rd_resp_fwd(rd_resp_fwd),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/sim_line_wbuf.sv
module sim_line_wbuf;
  localparam int DEPTH = 4;
  localparam int AW    = 26;
  localparam int LW    = 256;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          enq_valid = 1'b0, rd_req_valid = 1'b0;
  logic [AW-1:0] enq_addr = '0, rd_req_addr = '0;
  logic [LW-1:0] enq_data = '0;
  logic          mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [LW-1:0] mem_rdata = '0;
  logic          enq_stall, rd_req_ready, rd_resp_valid, rd_resp_fwd;
  logic          mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] rd_resp_data, mem_wdata;

  line_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_W(LW)) u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, rmode = 0, lat = 0;
  logic [AW-1:0] rd_pend_addr;
  logic [LW-1:0] backing [logic [AW-1:0]];
  logic [AW:0]   oplog[$];
  logic [LW:0]   resplog[$];

  // behavioural reference state
  logic [AW-1:0] mq_a[$];
  logic [LW-1:0] mq_d[$];
  bit m_busy, m_mv, m_mw, m_rv, m_rf;
  int m_st;
  logic [AW-1:0] m_raddr, m_ma;
  logic [LW-1:0] m_md, m_rd;

  function automatic logic [LW-1:0] dflt(logic [AW-1:0] a);
    logic [LW-1:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'(a) * 32'h9E3779B1 + 32'(k);
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_step();
    bit full_now, busy_now;
    int h;
    full_now = (mq_a.size() == DEPTH);
    busy_now = m_busy;
    m_rv = 0;
    case (m_st)
      0: if (busy_now) begin
           h = -1;
           for (int i = 0; i < mq_a.size(); i++) if (mq_a[i] == m_raddr) h = i;
           if (h >= 0) begin m_rv = 1; m_rf = 1; m_rd = mq_d[h]; m_busy = 0; end
           else begin m_mv = 1; m_mw = 0; m_ma = m_raddr; m_st = 1; end
         end else if (mq_a.size() > 0) begin
           m_mv = 1; m_mw = 1; m_ma = mq_a[0]; m_md = mq_d[0]; m_st = 3;
         end
      1: if (mem_ready) begin m_mv = 0; m_st = 2; end
      2: if (mem_rvalid) begin m_rv = 1; m_rf = 0; m_rd = mem_rdata; m_busy = 0; m_st = 0; end
      default: if (mem_ready) begin
           m_mv = 0; void'(mq_a.pop_front()); void'(mq_d.pop_front()); m_st = 0;
         end
    endcase
    if (rd_req_valid && !busy_now) begin m_busy = 1; m_raddr = rd_req_addr; end
    if (enq_valid && !full_now) begin mq_a.push_back(enq_addr); mq_d.push_back(enq_data); end
  endtask

  // memory model, reference model and per-cycle comparison in one process
  initial forever begin
    @(posedge clk);
    cyc++;
    if (rst) begin
      mq_a.delete(); mq_d.delete();
      m_busy = 0; m_mv = 0; m_mw = 0; m_rv = 0; m_rf = 0; m_st = 0; lat = 0;
    end else begin
      if (mem_valid && mem_ready) begin
        oplog.push_back({mem_write, mem_addr});
        if (mem_write) backing[mem_addr] = mem_wdata;
        else begin lat = 2; rd_pend_addr = mem_addr; end
      end
      if (rd_resp_valid) resplog.push_back({rd_resp_fwd, rd_resp_data});
      model_step();
    end
    @(negedge clk);
    if (!rst) begin
      chk(enq_stall == (mq_a.size() == DEPTH), "R2", "enq_stall", LW'(enq_stall), LW'(mq_a.size() == DEPTH));
      chk(rd_req_ready == !m_busy, "R10", "rd_req_ready", LW'(rd_req_ready), LW'(!m_busy));
      chk(mem_valid == m_mv, "R7", "mem_valid", LW'(mem_valid), LW'(m_mv));
      if (m_mv) begin
        chk(mem_write == m_mw, "R4", "mem_write", LW'(mem_write), LW'(m_mw));
        chk(mem_addr == m_ma, "R3", "mem_addr", LW'(mem_addr), LW'(m_ma));
        if (m_mw) chk(mem_wdata == m_md, "R3", "mem_wdata", mem_wdata, m_md);
      end
      chk(rd_resp_valid == m_rv, "R6", "rd_resp_valid", LW'(rd_resp_valid), LW'(m_rv));
      if (m_rv) begin
        chk(rd_resp_fwd == m_rf, "R5", "rd_resp_fwd", LW'(rd_resp_fwd), LW'(m_rf));
        chk(rd_resp_data == m_rd, "R5", "rd_resp_data", rd_resp_data, m_rd);
      end
    end
    mem_ready  = (rmode == 1) || (rmode == 2 && ($urandom % 4 != 0));
    mem_rvalid = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = backing.exists(rd_pend_addr) ? backing[rd_pend_addr] : dflt(rd_pend_addr);
      end
    end
  end

  initial begin
    @(posedge clk);
    while (cyc < 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  task automatic enq(logic [AW-1:0] a, logic [LW-1:0] d);
    enq_valid = 1'b1; enq_addr = a; enq_data = d;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic rdreq(logic [AW-1:0] a);
    while (!rd_req_ready) @(negedge clk);
    rd_req_valid = 1'b1; rd_req_addr = a;
    @(negedge clk);
    rd_req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mq_a.size() != 0 || m_busy || m_mv || lat != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!enq_stall && rd_req_ready && !mem_valid && !rd_resp_valid, "R1", "reset outputs",
        LW'({enq_stall, rd_req_ready, mem_valid, rd_resp_valid}), LW'(4'b0100));

    // R2 / R3: fill while memory is stalled, refuse a fifth, then drain in order
    rmode = 0;
    oplog.delete();
    for (int i = 0; i < 4; i++) enq(AW'(26'h10 + i), dflt(AW'(26'h1000 + i)));
    chk(enq_stall == 1'b1, "R2", "stall when four held", LW'(enq_stall), LW'(1));
    enq(26'h99, dflt(26'h99));
    rmode = 1;
    wait_idle();
    chk(oplog.size() == 4, "R2", "refused line not written", LW'(oplog.size()), LW'(4));
    for (int i = 0; i < 4 && i < oplog.size(); i++)
      chk(oplog[i] == {1'b1, AW'(26'h10 + i)}, "R3", "drain order", LW'(oplog[i]), LW'({1'b1, AW'(26'h10 + i)}));

    // R4 / R8: write in flight holds, miss read overtakes the rest
    rmode = 0;
    oplog.delete();
    for (int i = 0; i < 3; i++) enq(AW'(26'h20 + i), dflt(AW'(26'h2000 + i)));
    rdreq(26'h40);
    repeat (3) @(negedge clk);
    chk(mem_valid && mem_write && mem_addr == 26'h20, "R8", "in-flight write held",
        LW'({mem_valid, mem_write, mem_addr}), LW'({2'b11, 26'h20}));
    rmode = 1;
    wait_idle();
    chk(oplog.size() == 4, "R4", "op count", LW'(oplog.size()), LW'(4));
    if (oplog.size() == 4) begin
      chk(oplog[0] == {1'b1, 26'h20}, "R8", "first op", LW'(oplog[0]), LW'({1'b1, 26'h20}));
      chk(oplog[1] == {1'b0, 26'h40}, "R4", "read before pending writes", LW'(oplog[1]), LW'({1'b0, 26'h40}));
      chk(oplog[2] == {1'b1, 26'h21}, "R4", "writes resume", LW'(oplog[2]), LW'({1'b1, 26'h21}));
    end

    // R5: newest of two matching entries is forwarded, no memory read
    oplog.delete(); resplog.delete();
    enq(26'h35, dflt(26'h3500));
    enq(26'h30, dflt(26'h3000));
    enq_valid = 1'b1; enq_addr = 26'h30; enq_data = dflt(26'h3001);
    rd_req_valid = 1'b1; rd_req_addr = 26'h30;
    @(negedge clk);
    enq_valid = 1'b0; rd_req_valid = 1'b0;
    wait_idle();
    chk(resplog.size() == 1 && resplog[0] == {1'b1, dflt(26'h3001)}, "R5", "newest forwarded",
        resplog.size() > 0 ? resplog[0][LW-1:0] : '0, dflt(26'h3001));
    for (int i = 0; i < oplog.size(); i++)
      chk(oplog[i][AW] == 1'b1, "R5", "no memory read on forward", LW'(oplog[i]), LW'({1'b1, oplog[i][AW-1:0]}));

    // R9 / R6: victim parked, fill read goes first and returns memory data
    oplog.delete(); resplog.delete();
    enq_valid = 1'b1; enq_addr = 26'h50; enq_data = dflt(26'h5000);
    rd_req_valid = 1'b1; rd_req_addr = 26'h60;
    @(negedge clk);
    enq_valid = 1'b0; rd_req_valid = 1'b0;
    wait_idle();
    chk(oplog.size() == 2 && oplog[0] == {1'b0, 26'h60}, "R9", "read before victim",
        oplog.size() > 0 ? LW'(oplog[0]) : '0, LW'({1'b0, 26'h60}));
    chk(oplog.size() == 2 && oplog[1] == {1'b1, 26'h50}, "R9", "victim written last",
        oplog.size() > 1 ? LW'(oplog[1]) : '0, LW'({1'b1, 26'h50}));
    chk(resplog.size() == 1 && resplog[0] == {1'b0, dflt(26'h60)}, "R6", "memory read data",
        resplog.size() > 0 ? resplog[0][LW-1:0] : '0, dflt(26'h60));

    // R6: read after drain returns the written line from memory
    resplog.delete();
    rdreq(26'h21);
    wait_idle();
    chk(resplog.size() == 1 && resplog[0] == {1'b0, dflt(26'h2001)}, "R6", "read sees drained write",
        resplog.size() > 0 ? resplog[0][LW-1:0] : '0, dflt(26'h2001));

    // mixed traffic against the model every clock (R2 R3 R4 R5 R6 R7 R10)
    rmode = 2;
    for (int c = 0; c < 3000; c++) begin
      enq_valid    = ($urandom % 2 == 0);
      enq_addr     = AW'(26'h70 + ($urandom % 8));
      enq_data     = {8{$urandom}};
      rd_req_valid = rd_req_ready && ($urandom % 3 == 0);
      rd_req_addr  = AW'(26'h70 + ($urandom % 10));
      @(negedge clk);
    end
    enq_valid = 1'b0; rd_req_valid = 1'b0;
    wait_idle();
    finish_run();
  end
endmodule